// File: doc/BRIEF.md
# Priority-Encoded Interrupt Controller

This block gathers interrupt events from up to 64 senders and presents them to one receiver as a single combined request together with the index of the most urgent pending sender. Each sender's event pulse raises a pending flag that stays up until the receiver acknowledges that sender. A registered priority stage picks the lowest pending index and raises a valid flag when its result may be trusted. The acknowledge is then returned as a one-hot vector that drops only the named sender's flag.

A mode input turns the priority stage on. While it is off, requests still collect but no number is reported and nothing is acknowledged. An active-low interrupt enable holds off acknowledges without losing any pending request. After each acknowledge the block waits a fixed number of quiet cycles before the next one. This gives the priority stage a full cycle to settle on the next winner once the acknowledged flag has dropped.

Top module: `pei_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every pending flag, the reported number (to 0), the valid flag, the acknowledge vector and the spacing counter. They read as cleared at the first clock edge where reset is high.
- R2: A high bit `i` of `evt_i` at a clock edge sets `pend_o[i]` at that edge. The flag then stays set until sender `i` is acknowledged. An event that arrives in the same cycle as that sender's acknowledge keeps the flag set.
- R3: `any_req_o` is the OR of all bits of `pend_o`, in the same cycle.
- R4: With the mode input high, at each clock edge the stage registers in `req_num_o` the lowest index among the pending flags, leaving out a flag whose acknowledge is high in that cycle. Index 0 has the highest priority and index 63 the lowest. `num_vld_o` goes high exactly when such an index exists.
- R5: While `pe_mode_i` is low, `num_vld_o` is low and `req_num_o` is 0 from the next edge onward, and no acknowledge is issued. Pending flags still collect.
- R6: At an edge where the mode input is high, the enable input is low, `num_vld_o` is high and the spacing has run out, `ack_o` becomes one-hot at bit `req_num_o`. An event at edge k is acknowledged at edge k+2.
- R7: An acknowledge lasts exactly one cycle. At least two cycles with `ack_o` all zero follow it.
- R8: While `int_en_n_i` is high, no acknowledge is issued and pending flags are kept. The first edge after it returns low may issue an acknowledge.
- R9: An acknowledge clears only the pending flag of the sender it names, at the edge that ends the acknowledge cycle.
- R10: At most one bit of `ack_o` is ever high.
- R11: No acknowledge is issued at an edge where `num_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| pe_mode_i | input | 1 | Priority-encoded mode enable |
| int_en_n_i | input | 1 | Interrupt enable, active low (high holds off acknowledges) |
| evt_i | input | 64 | Per-sender event pulses |
| pend_o | output | 64 | Per-sender pending request flags |
| any_req_o | output | 1 | OR of all pending flags |
| req_num_o | output | 6 | Index of the highest-priority pending sender |
| num_vld_o | output | 1 | Marks `req_num_o` as trustworthy |
| ack_o | output | 64 | One-hot acknowledge routed back to the senders |

## Verification
A stale winner in the priority stage shows up one cycle after the acknowledge that should have removed it. `req_num_o` then still names the sender just served, and a later acknowledge lands on a sender whose flag is already down. A spacing counter that is too short or too long moves the next acknowledge off its expected edge, three cycles after the previous one. The directed scenarios fix that edge exactly. A mishandled pending flag becomes visible on `pend_o` one edge after the event or acknowledge that should have changed it. This covers flags that are lost, cleared for the wrong sender, or not re-armed by an event that coincides with an acknowledge.

// File: rtl/pei_pkg.sv
package pei_pkg;

   localparam int unsigned PEI_MAX_SRC = 64;

   function automatic int unsigned pei_idx_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit pei_is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/pei_src_bank.sv
module pei_src_bank #(
   parameter int unsigned NUM_SRC = 64
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] ack_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic               any_o
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic flag_q;
      always_ff @(posedge clk_i) begin
         if (rst_i)
            flag_q <= 1'b0;
         else
            flag_q <= (flag_q & ~ack_i[i]) | evt_i[i];
      end
      assign pend_o[i] = flag_q;
   end

   assign any_o = |pend_o;

   // R2: an event always leaves its flag set one edge later
   a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (rst_i)
      (($past(evt_i) & ~pend_o) == '0));

   // R9: an acknowledged flag without a fresh event is down afterwards
   a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (rst_i)
      (($past(ack_i & ~evt_i) & pend_o) == '0));

endmodule

// File: rtl/pei_prio_stage.sv
module pei_prio_stage #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned ID_W    = 6,
   parameter bit          GROUPED = 1'b1,
   parameter int unsigned GRP_W   = 8
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               en_i,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] ack_i,
   output logic [ID_W-1:0]    num_o,
   output logic               vld_o
);

   logic [NUM_SRC-1:0] masked;
   logic [ID_W-1:0]    win;
   logic               found;

   // a flag being acknowledged this cycle is gone at the next edge
   assign masked = pend_i & ~ack_i;

   if (GROUPED) begin : g_grouped
      localparam int unsigned NUM_GRP = (NUM_SRC + GRP_W - 1) / GRP_W;
      localparam int unsigned LOC_SH  = $clog2(GRP_W);

      logic [NUM_GRP*GRP_W-1:0] padded;
      logic [NUM_GRP-1:0]       grp_any;

      if (!pei_pkg::pei_is_pow2(GRP_W) || GRP_W < 2) begin : g_bad_grp
         $error("pei_prio_stage: GRP_W must be a power of two of at least 2");
      end

      always_comb begin
         padded = '0;
         padded[NUM_SRC-1:0] = masked;
      end

      for (genvar g = 0; g < NUM_GRP; g++) begin : g_any
         assign grp_any[g] = |padded[g*GRP_W +: GRP_W];
      end

      always_comb begin
         int unsigned      sel;
         int unsigned      loc;
         logic [GRP_W-1:0] slice;
         sel = 0;
         for (int g = NUM_GRP - 1; g >= 0; g--) begin
            if (grp_any[g]) sel = g;
         end
         slice = padded[sel*GRP_W +: GRP_W];
         loc = 0;
         for (int j = GRP_W - 1; j >= 0; j--) begin
            if (slice[j]) loc = j;
         end
         win   = ID_W'((sel << LOC_SH) + loc);
         found = |grp_any;
      end
   end else begin : g_linear
      always_comb begin
         win = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (masked[i]) win = ID_W'(i);
         end
         found = |masked;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i) begin
         num_o <= '0;
         vld_o <= 1'b0;
      end else begin
         num_o <= win;
         vld_o <= found;
      end
   end

   // R4: a valid number always names a sender that is still pending
   a_r4_num_pending: assert property (@(posedge clk_i) disable iff (rst_i)
      (vld_o |-> pend_i[num_o]));

   // R5: mode off leaves the number invalid and zero
   a_r5_mode_off: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(en_i) |-> (!vld_o && num_o == '0)));

endmodule

// File: rtl/pei_ack_ctrl.sv
module pei_ack_ctrl #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned ID_W    = 6,
   parameter int unsigned ACK_GAP = 2
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               mode_i,
   input  logic               hold_i,
   input  logic               vld_i,
   input  logic [ID_W-1:0]    num_i,
   output logic [NUM_SRC-1:0] ack_o
);

   localparam int unsigned GAP_W = pei_pkg::pei_idx_w(ACK_GAP + 1);

   logic [GAP_W-1:0]   gap_q;
   logic               issue;
   logic [NUM_SRC-1:0] ack_d;

   assign issue = mode_i && !hold_i && vld_i && (gap_q == '0);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
      assign ack_d[i] = issue && (num_i == ID_W'(i));
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         gap_q <= '0;
         ack_o <= '0;
      end else begin
         ack_o <= ack_d;
         if (issue)
            gap_q <= GAP_W'(ACK_GAP);
         else if (gap_q != '0)
            gap_q <= gap_q - 1'b1;
      end
   end

   // R10: never more than one sender acknowledged
   a_r10_one_ack: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(ack_o));

   // R7: the cycle after an acknowledge is quiet
   a_r7_gap_one: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(|ack_o) |-> !(|ack_o)));

   // R7: the second cycle after an acknowledge is quiet too
   a_r7_gap_two: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(|ack_o, 2) |-> !(|ack_o)));

   // R8: a held-off enable blocks the acknowledge
   a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(hold_i) |-> !(|ack_o)));

   // R11: an acknowledge needs a valid number before it
   a_r11_needs_vld: assert property (@(posedge clk_i) disable iff (rst_i)
      ((|ack_o) |-> $past(vld_i)));

endmodule

// File: rtl/pei_ctrl.sv
module pei_ctrl #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned ACK_GAP = 2,
   parameter bit          GROUPED = 1'b1,
   parameter int unsigned GRP_W   = 8,
   localparam int unsigned ID_W   = pei_pkg::pei_idx_w(NUM_SRC)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               pe_mode_i,
   input  logic               int_en_n_i,
   input  logic [NUM_SRC-1:0] evt_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic               any_req_o,
   output logic [ID_W-1:0]    req_num_o,
   output logic               num_vld_o,
   output logic [NUM_SRC-1:0] ack_o
);

   if (NUM_SRC < 2 || NUM_SRC > pei_pkg::PEI_MAX_SRC) begin : g_bad_src
      $error("pei_ctrl: NUM_SRC out of range");
   end
   if (ACK_GAP < 1) begin : g_bad_gap
      $error("pei_ctrl: ACK_GAP must be at least 1 so a stale number is never used");
   end

   pei_src_bank #(
      .NUM_SRC (NUM_SRC)
   ) src_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .evt_i  (evt_i),
      .ack_i  (ack_o),
      .pend_o (pend_o),
      .any_o  (any_req_o)
   );

   pei_prio_stage #(
      .NUM_SRC (NUM_SRC),
      .ID_W    (ID_W),
      .GROUPED (GROUPED),
      .GRP_W   (GRP_W)
   ) prio_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (pe_mode_i),
      .pend_i (pend_o),
      .ack_i  (ack_o),
      .num_o  (req_num_o),
      .vld_o  (num_vld_o)
   );

   pei_ack_ctrl #(
      .NUM_SRC (NUM_SRC),
      .ID_W    (ID_W),
      .ACK_GAP (ACK_GAP)
   ) ack_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .mode_i (pe_mode_i),
      .hold_i (int_en_n_i),
      .vld_i  (num_vld_o),
      .num_i  (req_num_o),
      .ack_o  (ack_o)
   );

   // R6: an acknowledge only ever targets a pending sender
   a_r6_ack_pending: assert property (@(posedge clk_i) disable iff (rst_i)
      ((ack_o & ~pend_o) == '0));

   // R3: combined request agrees with the flags
   a_r3_any_req: assert property (@(posedge clk_i) disable iff (rst_i)
      (any_req_o == (pend_o != '0)));

endmodule

// File: tb/pei_ctrl_tb.sv
`timescale 1ns/1ps
module pei_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pe_mode = 1'b1;
   logic        int_en_n = 1'b0;
   logic [63:0] evt = '0;
   logic [63:0] pend, ack;
   logic        any_req, num_vld;
   logic [5:0]  req_num;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pei_ctrl dut_i (
      .clk_i      (clk),
      .rst_i      (rst),
      .pe_mode_i  (pe_mode),
      .int_en_n_i (int_en_n),
      .evt_i      (evt),
      .pend_o     (pend),
      .any_req_o  (any_req),
      .req_num_o  (req_num),
      .num_vld_o  (num_vld),
      .ack_o      (ack)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse(input logic [63:0] m);
      evt = m;
      tick();
      evt = '0;
   endtask

   task automatic settle();
      for (int i = 0; i < 4; i++) tick();
   endtask

   function automatic logic [63:0] bit_of(input int i);
      return 64'd1 << i;
   endfunction

   task automatic t_reset_state();
      chk("R1", "pend", pend, '0);
      chk("R1", "ack", ack, '0);
      chk("R1", "vld", {63'd0, num_vld}, 64'd0);
      chk("R1", "num", {58'd0, req_num}, 64'd0);
      chk("R3", "any", {63'd0, any_req}, 64'd0);
   endtask

   task automatic t_single();
      pulse(bit_of(5));
      chk("R2", "pend set", pend, bit_of(5));
      chk("R3", "any set", {63'd0, any_req}, 64'd1);
      tick();
      chk("R4", "vld", {63'd0, num_vld}, 64'd1);
      chk("R4", "num", {58'd0, req_num}, 64'd5);
      chk("R6", "no early ack", ack, '0);
      tick();
      chk("R6", "ack at k+2", ack, bit_of(5));
      tick();
      chk("R7", "ack one cycle", ack, '0);
      chk("R9", "flag cleared", pend, '0);
      chk("R3", "any cleared", {63'd0, any_req}, 64'd0);
      tick();
      chk("R4", "vld drops", {63'd0, num_vld}, 64'd0);
      settle();
   endtask

   task automatic t_three_way();
      pulse(bit_of(40) | bit_of(3) | bit_of(63));
      chk("R3", "any multi", {63'd0, any_req}, 64'd1);
      for (int k = 2; k <= 10; k++) begin
         logic [63:0] exp;
         tick();
         exp = (k == 3) ? bit_of(3) : (k == 6) ? bit_of(40) : (k == 9) ? bit_of(63) : '0;
         chk("R7", $sformatf("ack cadence k=%0d", k), ack, exp);
         if (k == 2) chk("R4", "num first", {58'd0, req_num}, 64'd3);
         if (k == 4) chk("R4", "num second", {58'd0, req_num}, 64'd40);
         if (k == 4) chk("R9", "only winner cleared", pend, bit_of(40) | bit_of(63));
         if (k == 7) chk("R4", "num last", {58'd0, req_num}, 64'd63);
      end
      chk("R11", "vld low after last", {63'd0, num_vld}, 64'd0);
      chk("R9", "all cleared", pend, '0);
      settle();
   endtask

   task automatic t_hold();
      int_en_n = 1'b1;
      pulse(bit_of(7));
      tick();
      chk("R8", "num while held", {58'd0, req_num}, 64'd7);
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R8", "no ack while held", ack, '0);
      end
      chk("R8", "flag kept", pend, bit_of(7));
      int_en_n = 1'b0;
      tick();
      chk("R8", "ack after release", ack, bit_of(7));
      tick();
      chk("R9", "cleared after release", pend, '0);
      settle();
   endtask

   task automatic t_mode_off();
      pe_mode = 1'b0;
      pulse(bit_of(12));
      chk("R5", "flag collects", pend, bit_of(12));
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R5", "no ack", ack, '0);
         chk("R5", "vld low", {63'd0, num_vld}, 64'd0);
         chk("R5", "num zero", {58'd0, req_num}, 64'd0);
      end
      pe_mode = 1'b1;
      tick();
      chk("R5", "vld on enable", {63'd0, num_vld}, 64'd1);
      chk("R5", "num on enable", {58'd0, req_num}, 64'd12);
      tick();
      chk("R6", "ack after enable", ack, bit_of(12));
      tick();
      chk("R9", "cleared", pend, '0);
      settle();
   endtask

   task automatic t_preempt();
      pulse(bit_of(20));
      tick();
      evt = bit_of(1);
      tick();
      evt = '0;
      chk("R6", "ack uses registered number", ack, bit_of(20));
      chk("R2", "new flag set", pend, bit_of(20) | bit_of(1));
      tick();
      chk("R4", "num moves to higher prio", {58'd0, req_num}, 64'd1);
      chk("R9", "old winner cleared", pend, bit_of(1));
      tick();
      chk("R7", "gap second cycle", ack, '0);
      tick();
      chk("R6", "preempting ack", ack, bit_of(1));
      tick();
      chk("R9", "cleared", pend, '0);
      settle();
   endtask

   task automatic t_rearm();
      pulse(bit_of(9));
      tick();
      tick();
      chk("R6", "first ack", ack, bit_of(9));
      evt = bit_of(9);
      tick();
      evt = '0;
      chk("R2", "event with ack keeps flag", pend, bit_of(9));
      chk("R4", "vld low after ack", {63'd0, num_vld}, 64'd0);
      tick();
      chk("R4", "num recomputed", {58'd0, req_num}, 64'd9);
      tick();
      chk("R6", "second ack", ack, bit_of(9));
      tick();
      chk("R9", "cleared", pend, '0);
      settle();
   endtask

   task automatic t_mid_reset();
      pulse(bit_of(0) | bit_of(33));
      tick();
      tick();
      chk("R10", "one ack of two", ack, bit_of(0));
      rst = 1'b1;
      tick();
      rst = 1'b0;
      t_reset_state();
      pulse(bit_of(33));
      tick();
      chk("R1", "vld after reset", {63'd0, num_vld}, 64'd1);
      tick();
      chk("R1", "ack timing after reset", ack, bit_of(33));
      settle();
   endtask

   initial begin
      for (int i = 0; i < 3; i++) tick();
      t_reset_state();
      rst = 1'b0;
      tick();
      t_reset_state();
      t_single();
      t_three_way();
      t_hold();
      t_mode_off();
      t_preempt();
      t_rearm();
      t_mid_reset();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(20000 * 5);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule